// File: doc/BRIEF.md
# SDA Hold and Setup Sequencer

This block times the data line of the target side of an I2C transmitter. It watches the SCL level, which arrives already brought into the kernel clock domain. It sees each falling SCL edge after an optional delay line of programmable length. It then waits a programmable hold interval before it drives the next data bit onto SDA. Next it holds SCL low for a programmable setup interval before it releases the line. If the next bit has not been supplied when the hold interval ends, it keeps SCL low until the bit arrives. All intervals are counted in ticks of a shared divider. A tick lasts `cfg_tick_div`+1 kernel clocks.

A mode input forbids any pulling of SCL. In that mode the bit present at hold expiry goes out whether or not it was marked valid, and a one-cycle underrun pulse flags a missing bit. The SCL pull output is open-drain style: 1 drives the line low and 0 lets it float high.

The controller has four states. IDLE means SCL is high or the sequence is finished. HOLD counts the hold interval. STRETCH waits for late data with SCL held low. SETUP counts the setup interval with SCL held low. The transitions are:
- Any state goes to HOLD on a filtered falling edge.
- HOLD goes to IDLE if the filtered SCL is seen high. It also goes to IDLE at expiry when stretching is disabled.
- HOLD goes to SETUP at expiry when data is valid.
- HOLD goes to STRETCH at expiry when data is missing.
- STRETCH goes to SETUP when data becomes valid.
- STRETCH goes to IDLE if the filtered SCL is seen high.
- SETUP goes to IDLE when its count ends.

Top module: `sda_hold_setup_seq`

## Requirements
- R1: During and right after reset: `sda_o`=1, `scl_low_o`=0, `stretch_o`=0 and `underrun_o`=0.
- R2: A fall of `scl_in` is recognised `cfg_filt_len` clock edges later than it would be with a length of 0. With a length of 0, the first edge that samples `scl_in` low is the detection edge.
- R3: Let D be the detection edge. SDA takes its new value at edge D + `cfg_hold_units`×(`cfg_tick_div`+1) + 1. It does not change before that edge.
- R4: The bit driven is the value of `tx_bit` sampled at the hold-expiry edge. Earlier values have no effect.
- R5: Stretching is enabled and data is valid at hold expiry. Then `scl_low_o` is 1 for exactly (`cfg_setup_units`+1)×(`cfg_tick_div`+1) clocks, starting at the edge where SDA changes. SDA is stable over this window.
- R6: Stretching is enabled and `tx_valid` is 0 at hold expiry. Then `scl_low_o` and `stretch_o` go to 1 and SDA is kept. At the first edge that samples `tx_valid`=1, SDA takes `tx_bit`, `stretch_o` drops, and the R5 setup window starts.
- R7: With `cfg_stretch_dis`=1, `scl_low_o` never rises, and SDA takes `tx_bit` at the R3 edge.
- R8: With `cfg_stretch_dis`=1 and `tx_valid`=0 at hold expiry, `underrun_o` is 1 for exactly the one cycle after that edge.
- R9: A new filtered falling edge in any state restarts the full hold interval from that edge. It drops any pull of SCL at once.
- R10: If the filtered SCL is seen high during HOLD or STRETCH, the sequence is dropped without any change of SDA.
- R11: SDA changes only at edges where the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL level, already synchronised to `clk` |
| tx_valid | input | 1 | Next data bit is available |
| tx_bit | input | 1 | Next data bit |
| cfg_tick_div | input | 4 | Tick length minus one, in kernel clocks |
| cfg_hold_units | input | 4 | Hold interval in ticks |
| cfg_setup_units | input | 4 | Setup interval minus one, in ticks |
| cfg_filt_len | input | 4 | Extra SCL input delay in kernel clocks |
| cfg_stretch_dis | input | 1 | 1 forbids pulling SCL low |
| sda_o | output | 1 | SDA drive value |
| scl_low_o | output | 1 | 1 pulls SCL low |
| stretch_o | output | 1 | Waiting for late data with SCL held |
| underrun_o | output | 1 | One-cycle pulse: bit sent without valid data |

## Verification
Let the falling SCL input first be sampled at edge 1. The new SDA value is then due at edge 1 + filter length + hold units×(divider+1) + 1. The SCL pull starts on that same edge and ends (setup units+1)×(divider+1) edges later. For late data, the pull ends counting from the edge after `tx_valid` is raised. The bench works out these edge numbers for each run, for every configuration it draws. It then samples all four outputs at every falling clock edge over the whole window and compares each sample with the value due at that index. Because it compares every cycle, both early and late transitions are caught, including the R4 data change placed one cycle before expiry and the restarts of R9 and R10.

// File: rtl/sdas_pkg.sv
package sdas_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_STRETCH,
        ST_SETUP
    } seq_state_t;

endpackage

// File: rtl/sdas_delay_line.sv
// Tapped shift register: output is the input delayed by len clocks (0 = bypass).
module sdas_delay_line #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [LEN_W-1:0] len,
    output logic             dout
);
    localparam int DEPTH = (1 << LEN_W) - 1;

    logic stage_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[i] <= 1'b1;
                else        stage_q[i] <= din;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[i] <= 1'b1;
                else        stage_q[i] <= stage_q[i-1];
            end
        end
    end

    always_comb begin
        if (len == '0) dout = din;
        else           dout = stage_q[len - 1'b1];
    end

endmodule

// File: rtl/sdas_tick_gen.sv
// Divider producing one tick every (div+1) clocks, re-aligned by restart.
module sdas_tick_gen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (tick)    cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/sdas_fall_detect.sv
module sdas_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= lvl;
    end

    assign fall = prev_q & ~lvl;

endmodule

// File: rtl/sda_hold_setup_seq.sv
module sda_hold_setup_seq
    import sdas_pkg::*;
#(
    parameter int TICK_W = 4,
    parameter int UNIT_W = 4,
    parameter int FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              tx_valid,
    input  logic              tx_bit,
    input  logic [TICK_W-1:0] cfg_tick_div,
    input  logic [UNIT_W-1:0] cfg_hold_units,
    input  logic [UNIT_W-1:0] cfg_setup_units,
    input  logic [FILT_W-1:0] cfg_filt_len,
    input  logic              cfg_stretch_dis,
    output logic              sda_o,
    output logic              scl_low_o,
    output logic              stretch_o,
    output logic              underrun_o
);
    logic scl_filt;
    logic scl_fall;
    logic tick;
    logic restart;

    seq_state_t        state_q, state_d;
    logic [UNIT_W-1:0] units_q, units_d;
    logic              sda_q, sda_d;
    logic              und_q, und_d;

    sdas_delay_line #(.LEN_W(FILT_W)) u_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (scl_in),
        .len  (cfg_filt_len),
        .dout (scl_filt)
    );

    sdas_fall_detect u_fall (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (scl_filt),
        .fall (scl_fall)
    );

    sdas_tick_gen #(.DIV_W(TICK_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .div    (cfg_tick_div),
        .tick   (tick)
    );

    // Next-state and datapath decisions
    always_comb begin
        state_d = state_q;
        units_d = units_q;
        sda_d   = sda_q;
        und_d   = 1'b0;
        restart = 1'b0;
        if (scl_fall) begin
            state_d = ST_HOLD;
            units_d = cfg_hold_units;
            restart = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_HOLD: begin
                    if (scl_filt) begin
                        state_d = ST_IDLE;
                    end else if (units_q == '0) begin
                        if (cfg_stretch_dis) begin
                            sda_d   = tx_bit;
                            und_d   = ~tx_valid;
                            state_d = ST_IDLE;
                        end else if (tx_valid) begin
                            sda_d   = tx_bit;
                            state_d = ST_SETUP;
                            units_d = cfg_setup_units;
                            restart = 1'b1;
                        end else begin
                            state_d = ST_STRETCH;
                        end
                    end else if (tick) begin
                        units_d = units_q - 1'b1;
                    end
                end
                ST_STRETCH: begin
                    if (scl_filt) begin
                        state_d = ST_IDLE;
                    end else if (tx_valid) begin
                        sda_d   = tx_bit;
                        state_d = ST_SETUP;
                        units_d = cfg_setup_units;
                        restart = 1'b1;
                    end
                end
                ST_SETUP: begin
                    if (tick) begin
                        if (units_q == '0) state_d = ST_IDLE;
                        else               units_d = units_q - 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            units_q <= '0;
            sda_q   <= 1'b1;
            und_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            units_q <= units_d;
            sda_q   <= sda_d;
            und_q   <= und_d;
        end
    end

    // Outputs
    always_comb begin
        sda_o      = sda_q;
        underrun_o = und_q;
        stretch_o  = (state_q == ST_STRETCH);
        scl_low_o  = (state_q == ST_STRETCH) || (state_q == ST_SETUP);
    end

endmodule

// File: rtl/sda_hold_setup_seq_chk.sv
module sda_hold_setup_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_filt,
    input logic scl_fall,
    input logic tx_valid,
    input logic cfg_stretch_dis,
    input logic sda_o,
    input logic scl_low_o,
    input logic stretch_o,
    input logic underrun_o
);

    p_setup_sda_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_low_o && $past(scl_low_o) && !$past(stretch_o)) |-> $stable(sda_o));

    p_stretch_waits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stretch_o && !tx_valid && !scl_fall && !scl_filt) |=> (stretch_o && $stable(sda_o)));

    p_pull_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_low_o) |-> !$past(cfg_stretch_dis));

    p_underrun_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |-> ($past(cfg_stretch_dis) && !$past(tx_valid)));

    p_fall_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |=> (!scl_low_o && !stretch_o));

    p_sda_only_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_o != $past(sda_o)) |-> !$past(scl_filt));

endmodule

bind sda_hold_setup_seq sda_hold_setup_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .scl_filt       (scl_filt),
    .scl_fall       (scl_fall),
    .tx_valid       (tx_valid),
    .cfg_stretch_dis(cfg_stretch_dis),
    .sda_o          (sda_o),
    .scl_low_o      (scl_low_o),
    .stretch_o      (stretch_o),
    .underrun_o     (underrun_o)
);

// File: tb/sda_hold_setup_seq_tb.sv
`timescale 1ns/1ps
module sda_hold_setup_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_in = 1'b1;
    logic       tx_valid = 1'b0;
    logic       tx_bit = 1'b1;
    logic [3:0] cfg_tick_div = '0;
    logic [3:0] cfg_hold_units = '0;
    logic [3:0] cfg_setup_units = '0;
    logic [3:0] cfg_filt_len = '0;
    logic       cfg_stretch_dis = 1'b0;
    logic       sda_o, scl_low_o, stretch_o, underrun_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  exp_sda = 1'b1;

    always #2 clk = ~clk;

    sda_hold_setup_seq u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_in         (scl_in),
        .tx_valid       (tx_valid),
        .tx_bit         (tx_bit),
        .cfg_tick_div   (cfg_tick_div),
        .cfg_hold_units (cfg_hold_units),
        .cfg_setup_units(cfg_setup_units),
        .cfg_filt_len   (cfg_filt_len),
        .cfg_stretch_dis(cfg_stretch_dis),
        .sda_o          (sda_o),
        .scl_low_o      (scl_low_o),
        .stretch_o      (stretch_o),
        .underrun_o     (underrun_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // One bit: SCL drops at k=0; index k = k-th falling clock edge after that.
    task automatic run_seq(input int dv, input int sh, input int su, input int fl,
                           input bit nos, input bit vld, input int w, input int g);
        int  n, l, h0, h, kc, kf, ys, endk, lim;
        bit  old, b1, b2, aband;
        bit  e_sda, e_low, e_str, e_und;
        string rs, rl;
        n  = sh * (dv + 1) + 1;
        l  = (su + 1) * (dv + 1);
        h0 = 1 + fl + n;
        h  = h0;
        aband = 1'b0;
        kf = 0;
        if (g > 0) begin
            kc    = g + 1 + fl;
            aband = (kc <= h0);
            kf    = g + 3 + fl;
            h     = kf + n;
        end
        old = exp_sda;
        b1  = ~old;
        b2  = (g > 0 && !aband) ? old : b1;
        ys  = (!nos && !vld) ? h + w + 1 : h;
        endk = nos ? h + 2 : ys + l + 2;
        lim = (h0 + l < kf) ? h0 + l : kf;
        if (g > 0)     begin rs = "R9 R10 R11 sda"; rl = "R9 pull"; end
        else if (nos)  begin rs = "R7 sda";         rl = "R7 pull"; end
        else if (!vld) begin rs = "R6 sda";         rl = "R6 pull"; end
        else           begin rs = "R2 R3 R4 sda";   rl = "R5 pull"; end

        @(negedge clk);
        cfg_tick_div    = 4'(dv);
        cfg_hold_units  = 4'(sh);
        cfg_setup_units = 4'(su);
        cfg_filt_len    = 4'(fl);
        cfg_stretch_dis = nos;
        tx_valid = vld;
        tx_bit   = old;
        repeat (fl + 3) @(negedge clk);
        scl_in = 1'b0;
        for (int k = 1; k <= endk; k++) begin
            @(negedge clk);
            if (k >= ys)                        e_sda = b2;
            else if (g > 0 && !aband && k >= h0) e_sda = b1;
            else                                e_sda = old;
            e_low = 1'b0;
            if (!nos) begin
                if (k >= h && k < ys + l) e_low = 1'b1;
                if (g > 0 && !aband && k >= h0 && k < lim) e_low = 1'b1;
            end
            e_str = !nos && !vld && k >= h && k < ys;
            e_und = nos && !vld && k == h;
            chk(rs, sda_o, e_sda);
            chk(rl, scl_low_o, e_low);
            chk("R6 stretch", stretch_o, e_str);
            chk("R8 underrun", underrun_o, e_und);
            if (k == h0 - 1) tx_bit = b1;
            if (g > 0 && k == g) scl_in = 1'b1;
            if (g > 0 && k == g + 2) begin
                scl_in = 1'b0;
                tx_bit = b2;
            end
            if (!nos && !vld && k == h + w) tx_valid = 1'b1;
        end
        exp_sda  = b2;
        scl_in   = 1'b1;
        tx_valid = 1'b0;
        repeat (16) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 sda reset", sda_o, 1'b1);
        chk("R1 pull reset", scl_low_o, 1'b0);
        chk("R1 stretch reset", stretch_o, 1'b0);
        chk("R1 underrun reset", underrun_o, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 sda after reset", sda_o, 1'b1);
        chk("R1 pull after reset", scl_low_o, 1'b0);

        // directed corners
        run_seq(0, 0, 0, 0, 1'b0, 1'b1, -1, 0);   // minimum delays (R3, R5)
        run_seq(15, 15, 15, 0, 1'b0, 1'b1, -1, 0); // maximum divider and counts
        run_seq(0, 2, 1, 15, 1'b0, 1'b1, -1, 0);  // longest input delay (R2)
        run_seq(1, 2, 3, 1, 1'b0, 1'b0, 0, 0);    // late data, shortest wait (R6)
        run_seq(2, 1, 2, 0, 1'b0, 1'b0, 7, 0);    // late data, longer wait (R6)
        run_seq(1, 3, 0, 2, 1'b1, 1'b1, -1, 0);   // stretching disabled (R7)
        run_seq(1, 3, 0, 2, 1'b1, 1'b0, -1, 0);   // underrun (R8)
        run_seq(1, 4, 2, 0, 1'b0, 1'b1, -1, 3);   // SCL high in hold, refall (R9 R10)
        run_seq(0, 0, 7, 0, 1'b0, 1'b1, -1, 4);   // refall during setup (R9)

        // constrained random
        for (int t = 0; t < 200; t++) begin
            int dv, sh, su, fl, w;
            bit nos, vld;
            dv  = int'($urandom % 4);
            sh  = int'($urandom % 6);
            su  = int'($urandom % 6);
            fl  = int'($urandom % 4);
            nos = (($urandom % 4) == 0);
            vld = (($urandom % 3) != 0);
            w   = int'($urandom % 5);
            run_seq(dv, sh, su, fl, nos, vld, w, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule